// File: doc/BRIEF.md
# Three-Wire Serial Clock-Chip Transaction Engine

This block is the master side of a three-wire synchronous serial link to an external timekeeping chip. The three wires are a chip-enable, a serial clock and one bidirectional data line. A host starts one single-byte transfer with a one-cycle `start` pulse, a read/write flag, a 6-bit register address and (for a write) a data byte. The block then runs the whole transfer on the wires without further help.

Every transfer begins with all three wires low. Chip-enable is then raised and a command byte is shifted out. The command byte carries a fixed top bit, the address and the direction flag. A write follows the command with the data byte. A read releases the data line and clocks in a response byte under the same chip-enable window. Bits go out least-significant first. Each serial-clock half-period lasts `HALF_CYC` system clocks, so the link can be paced well below the slave's maximum rate. `busy` covers the transfer, and a one-cycle `done` pulse ends it. For a read, the result is then on `rdata`.

Top module: `rtc3w_master`

## Requirements
- R1: The command byte is bit 7 = 1, bits 6..1 = address[5:0], bit 0 = 1 for a read (`rd`=1) and 0 for a write.
- R2: Every byte on the link, sent or received, moves least-significant bit first, 8 bits per byte. Bit i of `rdata` is the i-th received sample.
- R3: After reset and between transfers, `ce_o`, `sclk_o`, `sio_o`, `busy` and `done` are 0 and `sio_oe` is 1, so the data line is driven low.
- R4: A write raises `ce_o` once and gives exactly 16 serial-clock pulses: the command byte and then the data byte. `sclk_o` is never high while `ce_o` is low.
- R5: A read raises `ce_o` once and gives 16 pulses. `sio_oe` is 0 for all of the last 8 pulses, and `sio_i` is sampled while `sclk_o` is low, just before each of those rising edges.
- R6: Each serial-clock high phase lasts exactly `HALF_CYC` system clock cycles.
- R7: `busy` is 1 from the cycle after an accepted `start` until the cycle in which `done` is 1. `done` is high for exactly one cycle per transfer.
- R8: A `start` pulse while `busy` is 1 is ignored: no second chip-enable window follows, and the running transfer is unchanged.
- R9: `sio_o` changes only while `sclk_o` is low.
- R10: Once `sio_oe` falls in a read, it stays 0 until `ce_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle transfer request |
| rd | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Register address in the clock chip |
| wdata | input | 8 | Byte to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rdata | output | 8 | Byte received by the last read |
| ce_o | output | 1 | Chip-enable wire |
| sclk_o | output | 1 | Serial clock wire |
| sio_o | output | 1 | Data value driven onto the data wire |
| sio_oe | output | 1 | Drive enable for the data wire |
| sio_i | input | 1 | Data wire as seen at the pad |

## Verification
The hardest case to reach is the turnaround in the middle of a read. The output enable must drop after the eighth command pulse and before the first receive sample. It must then stay low until chip-enable falls. Reaching this needs a slave that only answers after it has decoded the read flag. The bench models such a slave. It presents each response bit on the falling clock edge, so a master that sampled late or one bit early would return a shifted byte. A second case that is hard to reach is a start request in the middle of a transfer. The bench issues one with a different address and direction. It then confirms that the captured command matches the first request and that no second chip-enable window opens.

// File: rtl/rtc3w_pkg.sv
package rtc3w_pkg;
  localparam int ADDR_W = 6;
  localparam int BYTE_W = 8;
  localparam int XFER_BITS = 2 * BYTE_W;
  localparam int BIT_IDX_W = $clog2(XFER_BITS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CEUP,
    ST_LOW,
    ST_HIGH,
    ST_TAIL
  } seq_state_t;

  function automatic logic [BYTE_W-1:0] make_cmd(input logic [ADDR_W-1:0] a, input logic is_rd);
    make_cmd = {1'b1, a, is_rd};
  endfunction
endpackage

// File: rtl/rtc3w_pacer.sv
module rtc3w_pacer #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  generate
    if (HALF_CYC > 1) begin : g_spacing
      p_tick_spacing_r6: assert property (@(posedge clk) disable iff (rst) tick |=> !tick)
        else $error("tick repeated within one half period");
    end
  endgenerate
endmodule

// File: rtl/rtc3w_seq.sv
module rtc3w_seq
  import rtc3w_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              sio_i,
  output logic              run,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rdata,
  output logic              ce_o,
  output logic              sclk_o,
  output logic              sio_o,
  output logic              sio_oe
);
  seq_state_t               state;
  logic [XFER_BITS-1:0]     shreg;
  logic [BIT_IDX_W-1:0]     bitn;
  logic [BIT_IDX_W-1:0]     nxt;
  logic                     rd_q;

  assign run = (state != ST_IDLE);
  assign nxt = bitn + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      shreg  <= '0;
      bitn   <= '0;
      rd_q   <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
      rdata  <= '0;
      ce_o   <= 1'b0;
      sclk_o <= 1'b0;
      sio_o  <= 1'b0;
      sio_oe <= 1'b1;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            shreg  <= {wdata, make_cmd(addr, rd)};
            rd_q   <= rd;
            bitn   <= '0;
            busy   <= 1'b1;
            ce_o   <= 1'b0;
            sclk_o <= 1'b0;
            sio_o  <= 1'b0;
            sio_oe <= 1'b1;
            state  <= ST_SETUP;
          end
        end
        ST_SETUP: if (tick) begin
          ce_o  <= 1'b1;
          state <= ST_CEUP;
        end
        ST_CEUP: if (tick) begin
          sio_o <= shreg[0];
          state <= ST_LOW;
        end
        ST_LOW: if (tick) begin
          sclk_o <= 1'b1;
          if (rd_q && bitn[BIT_IDX_W-1]) rdata[bitn[BIT_IDX_W-2:0]] <= sio_i;
          state <= ST_HIGH;
        end
        ST_HIGH: if (tick) begin
          sclk_o <= 1'b0;
          if (bitn == BIT_IDX_W'(XFER_BITS - 1)) begin
            state <= ST_TAIL;
          end else begin
            bitn  <= nxt;
            shreg <= shreg >> 1;
            if (rd_q && nxt[BIT_IDX_W-1]) begin
              sio_oe <= 1'b0;
              sio_o  <= 1'b0;
            end else begin
              sio_o <= shreg[1];
            end
            state <= ST_LOW;
          end
        end
        ST_TAIL: if (tick) begin
          ce_o   <= 1'b0;
          sio_oe <= 1'b1;
          sio_o  <= 1'b0;
          busy   <= 1'b0;
          done   <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_sclk_needs_ce_r4: assert property (@(posedge clk) disable iff (rst) sclk_o |-> ce_o)
    else $error("serial clock high outside chip-enable");
  p_sio_stable_r9: assert property (@(posedge clk) disable iff (rst) (sclk_o && $past(sclk_o)) |-> $stable(sio_o))
    else $error("data moved while serial clock high");
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst) done |=> !done)
    else $error("done longer than one cycle");
  p_done_not_busy_r7: assert property (@(posedge clk) disable iff (rst) done |-> !busy)
    else $error("busy still high with done");
  p_oe_hold_r10: assert property (@(posedge clk) disable iff (rst) (ce_o && !sio_oe) |=> (!sio_oe || !ce_o))
    else $error("drive enable returned inside chip-enable window");
  p_idle_low_r3: assert property (@(posedge clk) disable iff (rst) !busy |-> (!ce_o && !sclk_o))
    else $error("wires active while not busy");
endmodule

// File: rtl/rtc3w_master.sv
module rtc3w_master
  import rtc3w_pkg::*;
#(
  parameter int HALF_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rdata,
  output logic              ce_o,
  output logic              sclk_o,
  output logic              sio_o,
  output logic              sio_oe,
  input  logic              sio_i
);
  logic run;
  logic tick;

  rtc3w_pacer #(.HALF_CYC(HALF_CYC)) pacer_i (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick)
  );

  rtc3w_seq seq_i (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .start  (start),
    .rd     (rd),
    .addr   (addr),
    .wdata  (wdata),
    .sio_i  (sio_i),
    .run    (run),
    .busy   (busy),
    .done   (done),
    .rdata  (rdata),
    .ce_o   (ce_o),
    .sclk_o (sclk_o),
    .sio_o  (sio_o),
    .sio_oe (sio_oe)
  );
endmodule

// File: tb/rtc3w_master_tb_top.sv
`timescale 1ns/1ps
module rtc3w_master_tb_top;
  localparam int HALF = 4;
  localparam int NVEC = 6;
  localparam logic [14:0] VEC [NVEC] = '{
    {1'b0, 6'd0,  8'hA5},
    {1'b1, 6'd63, 8'h01},
    {1'b0, 6'd21, 8'h80},
    {1'b1, 6'd42, 8'hC3},
    {1'b0, 6'd63, 8'hFE},
    {1'b1, 6'd1,  8'h5A}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic rd = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic busy, done, ce_o, sclk_o, sio_o, sio_oe;
  logic [7:0] rdata;
  logic slave_drv = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int ce_rises = 0, pulses = 0, hi_len = 0;
  int pace_bad = 0, stab_bad = 0, oe_bad = 0, done_cnt = 0;
  logic [7:0] got_cmd = '0, got_dat = '0, resp = '0;
  logic p_ce = 1'b0, p_sclk = 1'b0, p_sio = 1'b0, seen_low = 1'b0;

  always #2.5 clk = ~clk;

  rtc3w_master #(.HALF_CYC(HALF)) dut_i (
    .clk(clk), .rst(rst), .start(start), .rd(rd), .addr(addr), .wdata(wdata),
    .busy(busy), .done(done), .rdata(rdata), .ce_o(ce_o), .sclk_o(sclk_o),
    .sio_o(sio_o), .sio_oe(sio_oe), .sio_i(slave_drv)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // slave model and line monitor, sampled away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (ce_o && !p_ce) begin
      ce_rises++; pulses = 0; seen_low = 1'b0; got_cmd = '0; got_dat = '0;
    end
    if (sclk_o && !p_sclk) begin
      if (pulses < 8) got_cmd[pulses] = sio_o;
      else if (pulses < 16) begin
        if (got_cmd[0]) begin
          if (sio_oe) oe_bad++;
        end else got_dat[pulses-8] = sio_o;
      end
      pulses++; hi_len = 0; p_sio = sio_o;
    end
    if (sclk_o) begin
      hi_len++;
      if (sio_o != p_sio) stab_bad++;
    end
    if (!sclk_o && p_sclk) begin
      if (hi_len != HALF) pace_bad++;
      if (got_cmd[0] && pulses >= 8 && pulses < 16) slave_drv = resp[pulses-8];
    end
    if (!sio_oe) seen_low = 1'b1;
    if (ce_o && seen_low && sio_oe) oe_bad++;
    if (done) done_cnt++;
    p_ce = ce_o; p_sclk = sclk_o;
  end

  always @(negedge clk) begin
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected 0", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
  endtask

  task automatic run_txn(input bit r, input logic [5:0] a, input logic [7:0] d, input bit poke);
    int ce0, dn0, pb0, sb0, ob0;
    bit seen;
    logic [7:0] exp_cmd;
    exp_cmd = {1'b1, a, r};
    ce0 = ce_rises; dn0 = done_cnt; pb0 = pace_bad; sb0 = stab_bad; ob0 = oe_bad;
    resp = d; slave_drv = 1'b0;
    @(negedge clk);
    start = 1'b1; rd = r; addr = a; wdata = r ? 8'h00 : d;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7 busy after start", busy, 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      start = 1'b1; rd = ~r; addr = ~a; wdata = ~d;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done(seen);
    chk(seen, "R7 done seen", seen, 1);
    chk(busy == 1'b0, "R7 busy low at done", busy, 0);
    repeat (3) @(negedge clk);
    chk(got_cmd == exp_cmd, "R1 command byte", got_cmd, exp_cmd);
    chk(pulses == 16, r ? "R5 pulse count" : "R4 pulse count", pulses, 16);
    chk(ce_rises - ce0 == 1, r ? "R5 one chip-enable window" : "R4 one chip-enable window", ce_rises - ce0, 1);
    if (r) begin
      chk(rdata == d, "R2 R5 read byte LSB first", rdata, d);
      chk(oe_bad == ob0, "R5 R10 drive enable low for receive", oe_bad - ob0, 0);
    end else begin
      chk(got_dat == d, "R2 R4 write byte LSB first", got_dat, d);
    end
    chk(pace_bad == pb0, "R6 high phase length", pace_bad - pb0, 0);
    chk(stab_bad == sb0, "R9 data stable while clock high", stab_bad - sb0, 0);
    chk(done_cnt - dn0 == 1, "R7 done one cycle", done_cnt - dn0, 1);
    chk(!ce_o && !sclk_o && !sio_o && sio_oe, "R3 idle lines", {ce_o, sclk_o, sio_o, sio_oe}, 4'b0001);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!ce_o && !sclk_o && !sio_o && sio_oe, "R3 reset lines", {ce_o, sclk_o, sio_o, sio_oe}, 4'b0001);
    chk(!busy && !done, "R3 reset handshake", {busy, done}, 0);

    for (int v = 0; v < NVEC; v++)
      run_txn(VEC[v][14], VEC[v][13:8], VEC[v][7:0], 1'b0);

    // R8: start while busy must be ignored
    begin
      int ce_before;
      run_txn(1'b0, 6'd9, 8'h3C, 1'b1);
      ce_before = ce_rises;
      repeat (100) @(negedge clk);
      chk(ce_rises == ce_before, "R8 no second window", ce_rises - ce_before, 0);
      chk(!busy && !ce_o, "R8 stays idle", {busy, ce_o}, 0);
    end

    // back-to-back read straight after a write
    run_txn(1'b1, 6'd0, 8'hFF, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule